// File: doc/BRIEF.md
# Display Serial Command Packet Writer

This block turns command-write requests into the words that a serial display link controller keeps in two queues: a 32-bit payload queue and a header queue. A request carries an 8-bit data-type code and a 16-bit byte count. The bytes themselves arrive on a separate byte stream with a valid/ready handshake. The block sorts the data type into one of four kinds:

- **Header-only:** takes two parameter bytes from the stream and writes a single header.
- **Long write:** packs the stream into little-endian payload words, then writes a header that carries the count.
- **Skip:** completes without writing anything.
- **Unsupported:** completes with an error.

Each request ends with a one-cycle completion pulse and a result code. The link mode input controls admission. Ultra-low-power mode rejects every request. Low-power stop mode holds a request until the header queue reports empty, and fails it if that does not happen in time. The other two modes send at once.

Top module: `dsi_cmd_writer`

## Requirements
- R1: A request accepted while `link_mode` is 3 (ultra-low-power) takes no bytes and writes nothing. In the next cycle it completes with `done_code` 1.
- R2: With `link_mode` 1 (low-power stop), nothing is consumed or written while `hdr_fifo_empty` is low. Once it is seen high, the request proceeds normally.
- R3: In low-power stop mode, if `hdr_fifo_empty` stays low for POLL_LIMIT consecutive polls (one per cycle, default 10000), the request completes with `done_code` 2 and writes nothing. The completion pulse appears POLL_LIMIT+1 cycles after the accepting edge.
- R4: Long writes (types 0x29, 0x39) pack bytes little-endian. Stream byte 4k+j goes to payload word k, bits 8j+7:8j.
- R5: When the byte count is 4 or more and not a multiple of 4, the last payload word holds the remaining 1 to 3 bytes in its low lanes, and its upper lanes are zero.
- R6: A long write with a count of 0 to 3 consumes exactly three bytes and writes exactly one payload word, with those bytes in bits 23:0 and zero in bits 31:24.
- R7: A long write's header is written only after its last payload word. The header holds the type in bits 7:0, count[7:0] in bits 15:8 and count[15:8] in bits 23:16.
- R8: Header-only types consume exactly two bytes (p0 then p1) and write one header {p1, p0, type} with no payload. These types are 0x02, 0x03, 0x04, 0x05, 0x06, 0x12, 0x13, 0x14, 0x15, 0x22, 0x23, 0x24, 0x32 and 0x37.
- R9: Skip types complete with `done_code` 0, consume no bytes and write nothing. These types are 0x01, 0x08, 0x09, 0x11, 0x19, 0x21 and 0x31.
- R10: Any other type completes with `done_code` 3, consumes no bytes and writes nothing. In modes 0 and 2, the completion pulse comes two cycles after the accepting edge.
- R11: `req_ready` is high only when the block is idle. A payload or header word that is not accepted is held steady until it is. `done_valid` is high for one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_mode | input | 2 | Link mode: 0 idle, 1 low-power stop, 2 high-speed, 3 ultra-low-power |
| hdr_fifo_empty | input | 1 | Header queue reports empty |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_dtype | input | 8 | Packet data type |
| req_count | input | CNT_W | Byte count |
| byte_valid | input | 1 | Stream byte offered |
| byte_ready | output | 1 | Stream byte taken |
| byte_data | input | BYTE_W | Stream byte |
| pld_valid | output | 1 | Payload word offered |
| pld_ready | input | 1 | Payload queue accepts |
| pld_data | output | LANES*BYTE_W | Payload word |
| hdr_valid | output | 1 | Header word offered |
| hdr_ready | input | 1 | Header queue accepts |
| hdr_data | output | 8+2*BYTE_W | Header word |
| done_valid | output | 1 | Request complete (one cycle) |
| done_code | output | 2 | 0 ok, 1 link asleep, 2 drain timeout, 3 unsupported |

## Verification
The hardest situation to reach from the ports is a request stuck in the low-power drain wait. This covers both the pass case and the case where the wait runs out after thousands of polls.

The stimulus reaches it by holding `hdr_fifo_empty` low while a request is pending in mode 1:
- Part way through the wait, the bench confirms that no byte was taken and no word was written.
- It then releases the input for the pass case.
- For the failure case it keeps the input low and measures the exact cycle of the completion pulse.

Ready back-pressure on both output queues is applied during long writes, so words must stay stable while stalled.

// File: rtl/dsi_cmd_pkg.sv
package dsi_cmd_pkg;

   localparam int DT_W = 8;

   typedef enum logic [1:0] {
      PK_SHORT = 2'd0,
      PK_LONG  = 2'd1,
      PK_SKIP  = 2'd2,
      PK_BAD   = 2'd3
   } pkt_kind_t;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_ASLEEP  = 2'd1,
      RES_TIMEOUT = 2'd2,
      RES_UNSUPP  = 2'd3
   } result_t;

   localparam logic [1:0] LM_LOWPOWER = 2'd1;
   localparam logic [1:0] LM_SLEEP    = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GATE,
      ST_DISPATCH,
      ST_PARAMS,
      ST_PACK,
      ST_HEADER,
      ST_DONE
   } wr_state_t;

   function automatic pkt_kind_t kind_of(input logic [DT_W-1:0] dt);
      case (dt)
         8'h02, 8'h03, 8'h04, 8'h05, 8'h06,
         8'h12, 8'h13, 8'h14, 8'h15,
         8'h22, 8'h23, 8'h24, 8'h32, 8'h37: kind_of = PK_SHORT;
         8'h29, 8'h39:                      kind_of = PK_LONG;
         8'h01, 8'h08, 8'h09, 8'h11,
         8'h19, 8'h21, 8'h31:               kind_of = PK_SKIP;
         default:                           kind_of = PK_BAD;
      endcase
   endfunction

endpackage

// File: rtl/dsi_type_decoder.sv
module dsi_type_decoder
   import dsi_cmd_pkg::*;
(
   input  logic [DT_W-1:0] dtype,
   output pkt_kind_t       kind
);
   assign kind = kind_of(dtype);
endmodule

// File: rtl/dsi_lp_gate.sv
module dsi_lp_gate #(
   parameter int LIMIT = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic fifo_empty,
   output logic pass,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] polls_q;

   assign pass   = active && fifo_empty;
   assign expire = active && !fifo_empty && (polls_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         polls_q <= '0;
      end else if (!active || fifo_empty || expire) begin
         polls_q <= '0;
      end else begin
         polls_q <= polls_q + CW'(1);
      end
   end
endmodule

// File: rtl/dsi_word_packer.sv
module dsi_word_packer #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   parameter int CNT_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [CNT_W-1:0]          load_total,
   input  logic                      enable,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [BYTE_W-1:0]         in_data,
   output logic                      word_valid,
   input  logic                      word_ready,
   output logic [LANES*BYTE_W-1:0]   word_data,
   output logic                      drained
);
   localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   logic [CNT_W-1:0]  remain_q;
   logic [LIDX_W-1:0] lane_q;
   logic              full_q;
   logic              in_fire;
   logic              word_fire;
   logic              last_lane;

   assign in_ready   = enable && !full_q && (remain_q != '0);
   assign in_fire    = in_valid && in_ready;
   assign word_valid = full_q;
   assign word_fire  = full_q && word_ready;
   assign drained    = (remain_q == '0) && !full_q;
   assign last_lane  = (lane_q == LIDX_W'(LANES - 1)) || (remain_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
         lane_q   <= '0;
         full_q   <= 1'b0;
      end else if (load) begin
         remain_q <= load_total;
         lane_q   <= '0;
         full_q   <= 1'b0;
      end else begin
         if (in_fire) begin
            remain_q <= remain_q - CNT_W'(1);
            if (last_lane) begin
               full_q <= 1'b1;
               lane_q <= '0;
            end else begin
               lane_q <= lane_q + LIDX_W'(1);
            end
         end
         if (word_fire) begin
            full_q <= 1'b0;
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_byte_q <= '0;
         end else if (load || word_fire) begin
            lane_byte_q <= '0;
         end else if (in_fire && (lane_q == LIDX_W'(g))) begin
            lane_byte_q <= in_data;
         end
      end
      assign word_data[g*BYTE_W +: BYTE_W] = lane_byte_q;
   end
endmodule

// File: rtl/dsi_header_stage.sv
module dsi_header_stage #(
   parameter int DTW    = 8,
   parameter int BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [DTW-1:0]          ld_type,
   input  logic [BYTE_W-1:0]       ld_p0,
   input  logic [BYTE_W-1:0]       ld_p1,
   output logic                    hdr_valid,
   input  logic                    hdr_ready,
   output logic [DTW+2*BYTE_W-1:0] hdr_data
);
   logic valid_q;
   logic [DTW+2*BYTE_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         word_q  <= '0;
      end else if (load) begin
         valid_q <= 1'b1;
         word_q  <= {ld_p1, ld_p0, ld_type};
      end else if (valid_q && hdr_ready) begin
         valid_q <= 1'b0;
      end
   end

   assign hdr_valid = valid_q;
   assign hdr_data  = word_q;
endmodule

// File: rtl/dsi_cmd_writer.sv
module dsi_cmd_writer
   import dsi_cmd_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int LANES      = 4,
   parameter int CNT_W      = 16,
   parameter int POLL_LIMIT = 10000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                link_mode,
   input  logic                      hdr_fifo_empty,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [DT_W-1:0]           req_dtype,
   input  logic [CNT_W-1:0]          req_count,
   input  logic                      byte_valid,
   output logic                      byte_ready,
   input  logic [BYTE_W-1:0]         byte_data,
   output logic                      pld_valid,
   input  logic                      pld_ready,
   output logic [LANES*BYTE_W-1:0]   pld_data,
   output logic                      hdr_valid,
   input  logic                      hdr_ready,
   output logic [DT_W+2*BYTE_W-1:0]  hdr_data,
   output logic                      done_valid,
   output logic [1:0]                done_code
);
   localparam int SHORT_FILL = LANES - 1;

   if (CNT_W != 2 * BYTE_W) begin : g_bad_cnt
      $error("count width must span exactly two header parameter bytes");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("payload word needs at least two byte lanes");
   end
   if (POLL_LIMIT < 2) begin : g_bad_limit
      $error("drain poll limit must be at least two");
   end

   wr_state_t         st_q, st_d;
   logic [DT_W-1:0]   dt_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] p0_q;
   logic              pidx_q;
   result_t           res_q;

   pkt_kind_t         kind;
   logic              gate_pass, gate_expire;
   logic              pk_load, pk_in_ready, pk_drained;
   logic [CNT_W-1:0]  pk_total;
   logic              hdr_load;
   logic [BYTE_W-1:0] hdr_p0, hdr_p1;
   logic              req_fire, param_fire;

   dsi_type_decoder u_dec (
      .dtype (dt_q),
      .kind  (kind)
   );

   dsi_lp_gate #(.LIMIT(POLL_LIMIT)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (st_q == ST_GATE),
      .fifo_empty (hdr_fifo_empty),
      .pass       (gate_pass),
      .expire     (gate_expire)
   );

   assign pk_load  = (st_q == ST_DISPATCH) && (kind == PK_LONG);
   assign pk_total = (cnt_q < CNT_W'(LANES)) ? CNT_W'(SHORT_FILL) : cnt_q;

   dsi_word_packer #(.BYTE_W(BYTE_W), .LANES(LANES), .CNT_W(CNT_W)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (pk_load),
      .load_total (pk_total),
      .enable     (st_q == ST_PACK),
      .in_valid   (byte_valid),
      .in_ready   (pk_in_ready),
      .in_data    (byte_data),
      .word_valid (pld_valid),
      .word_ready (pld_ready),
      .word_data  (pld_data),
      .drained    (pk_drained)
   );

   assign param_fire = (st_q == ST_PARAMS) && byte_valid;
   assign hdr_load   = (param_fire && pidx_q) || ((st_q == ST_PACK) && pk_drained);
   assign hdr_p0     = (st_q == ST_PARAMS) ? p0_q : cnt_q[BYTE_W-1:0];
   assign hdr_p1     = (st_q == ST_PARAMS) ? byte_data : cnt_q[2*BYTE_W-1:BYTE_W];

   dsi_header_stage #(.DTW(DT_W), .BYTE_W(BYTE_W)) u_hdr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (hdr_load),
      .ld_type   (dt_q),
      .ld_p0     (hdr_p0),
      .ld_p1     (hdr_p1),
      .hdr_valid (hdr_valid),
      .hdr_ready (hdr_ready),
      .hdr_data  (hdr_data)
   );

   assign req_ready  = (st_q == ST_IDLE);
   assign req_fire   = req_valid && req_ready;
   assign byte_ready = (st_q == ST_PARAMS) || pk_in_ready;
   assign done_valid = (st_q == ST_DONE);
   assign done_code  = res_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: begin
            if (req_valid) begin
               if (link_mode == LM_SLEEP)         st_d = ST_DONE;
               else if (link_mode == LM_LOWPOWER) st_d = ST_GATE;
               else                               st_d = ST_DISPATCH;
            end
         end
         ST_GATE: begin
            if (gate_pass)        st_d = ST_DISPATCH;
            else if (gate_expire) st_d = ST_DONE;
         end
         ST_DISPATCH: begin
            case (kind)
               PK_SHORT: st_d = ST_PARAMS;
               PK_LONG:  st_d = ST_PACK;
               default:  st_d = ST_DONE;
            endcase
         end
         ST_PARAMS: if (param_fire && pidx_q) st_d = ST_HEADER;
         ST_PACK:   if (pk_drained) st_d = ST_HEADER;
         ST_HEADER: if (hdr_valid && hdr_ready) st_d = ST_DONE;
         ST_DONE:   st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         dt_q   <= '0;
         cnt_q  <= '0;
         p0_q   <= '0;
         pidx_q <= 1'b0;
         res_q  <= RES_OK;
      end else begin
         st_q <= st_d;
         if (req_fire) begin
            dt_q   <= req_dtype;
            cnt_q  <= req_count;
            pidx_q <= 1'b0;
            res_q  <= (link_mode == LM_SLEEP) ? RES_ASLEEP : RES_OK;
         end
         if ((st_q == ST_GATE) && !gate_pass && gate_expire) begin
            res_q <= RES_TIMEOUT;
         end
         if ((st_q == ST_DISPATCH) && (kind == PK_BAD)) begin
            res_q <= RES_UNSUPP;
         end
         if (param_fire && !pidx_q) begin
            p0_q   <= byte_data;
            pidx_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dsi_cmd_writer_chk.sv
module dsi_cmd_writer_chk
   import dsi_cmd_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [1:0]               link_mode,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [DT_W-1:0]          req_dtype,
   input logic                     pld_valid,
   input logic                     pld_ready,
   input logic [LANES*BYTE_W-1:0]  pld_data,
   input logic                     hdr_valid,
   input logic                     hdr_ready,
   input logic [DT_W+2*BYTE_W-1:0] hdr_data,
   input logic                     done_valid,
   input logic [1:0]               done_code
);
   logic req_fire;
   logic direct_mode;
   assign req_fire    = req_valid && req_ready;
   assign direct_mode = (link_mode == 2'd0) || (link_mode == 2'd2);

   assert_pld_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pld_valid && !pld_ready) |=> (pld_valid && $stable(pld_data)));

   assert_hdr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_data)));

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_sleep_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && (link_mode == 2'd3)) |=> (done_valid && (done_code == 2'd1)));

   assert_unsupported_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && direct_mode && (kind_of(req_dtype) == PK_BAD))
      |=> ##1 (done_valid && (done_code == 2'd3)));

   assert_skip_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && direct_mode && (kind_of(req_dtype) == PK_SKIP))
      |=> ##1 (done_valid && (done_code == 2'd0)));

   assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(pld_valid && hdr_valid));
endmodule

bind dsi_cmd_writer dsi_cmd_writer_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (.*);

// File: tb/dsi_cmd_writer_bench.sv
`timescale 1ns/100ps
module dsi_cmd_writer_bench;
   localparam int LIMIT = 10000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  link_mode = 2'd2;
   logic        hdr_fifo_empty = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_dtype = '0;
   logic [15:0] req_count = '0;
   logic        byte_valid = 1'b0;
   logic        byte_ready;
   logic [7:0]  byte_data = '0;
   logic        pld_valid;
   logic        pld_ready = 1'b1;
   logic [31:0] pld_data;
   logic        hdr_valid;
   logic        hdr_ready = 1'b1;
   logic [23:0] hdr_data;
   logic        done_valid;
   logic [1:0]  done_code;

   always #2.5 clk = ~clk;

   dsi_cmd_writer #(.POLL_LIMIT(LIMIT)) u_dsi_cmd_writer (
      .clk(clk), .rst_n(rst_n), .link_mode(link_mode), .hdr_fifo_empty(hdr_fifo_empty),
      .req_valid(req_valid), .req_ready(req_ready), .req_dtype(req_dtype), .req_count(req_count),
      .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
      .pld_valid(pld_valid), .pld_ready(pld_ready), .pld_data(pld_data),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
      .done_valid(done_valid), .done_code(done_code)
   );

   logic [7:0]  bq[$];
   logic [31:0] exp_pld[$];
   logic [23:0] exp_hdr[$];
   logic [1:0]  exp_done[$];
   int vectors = 0, miscompares = 0;
   int consumed = 0, writes = 0, dones = 0, cyc = 0, acc_cyc = 0, done_cyc = 0;
   bit req_seen = 0, stall_en = 0;
   logic [7:0] lfsr = 8'h5A;
   logic [7:0] seed = 8'h11;
   string cur_tag = "none";

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver of stream/ready inputs, then monitor of handshakes that fire at the next edge
   always @(negedge clk) begin
      cyc++;
      byte_valid = (bq.size() > 0);
      byte_data  = (bq.size() > 0) ? bq[0] : 8'h00;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pld_ready = stall_en ? (lfsr[0] & lfsr[2]) : 1'b1;
      hdr_ready = stall_en ? lfsr[1] : 1'b1;
      #1;
      if (rst_n) begin
         if (req_valid && req_ready) begin
            req_seen = 1;
            acc_cyc = cyc;
         end
         if (byte_valid && byte_ready) begin
            void'(bq.pop_front());
            consumed++;
         end
         if (pld_valid && pld_ready) begin
            writes++;
            if (exp_pld.size() == 0) check(0, {cur_tag, " unexpected payload word"}, pld_data, 0);
            else begin
               logic [31:0] e;
               e = exp_pld.pop_front();
               check(pld_data == e, {cur_tag, " payload word"}, pld_data, e);
            end
         end
         if (hdr_valid && hdr_ready) begin
            writes++;
            check(exp_pld.size() == 0, {cur_tag, " R7 header before payload end"}, exp_pld.size(), 0);
            if (exp_hdr.size() == 0) check(0, {cur_tag, " unexpected header"}, hdr_data, 0);
            else begin
               logic [23:0] e;
               e = exp_hdr.pop_front();
               check(hdr_data == e, {cur_tag, " header word"}, hdr_data, e);
            end
         end
         if (done_valid) begin
            dones++;
            done_cyc = cyc;
            if (exp_done.size() == 0) check(0, {cur_tag, " R11 extra completion"}, done_code, 0);
            else begin
               logic [1:0] e;
               e = exp_done.pop_front();
               check(done_code == e, {cur_tag, " result code"}, done_code, e);
            end
         end
      end
   end

   // kind: 0 header-only, 1 long write, 2 nothing written
   task automatic do_req(input logic [7:0] dt, input int cnt, input logic [1:0] mode,
                         input int kind, input logic [1:0] code, input string tag);
      logic [15:0] c16;
      logic [7:0]  b[$];
      int n, cons, d0;
      c16 = cnt[15:0];
      cons = 0;
      if (kind == 1) begin
         n = (cnt < 4) ? 3 : cnt;
         for (int i = 0; i < n; i++) b.push_back(seed + 8'(i * 7));
         for (int w = 0; w < (n + 3) / 4; w++) begin
            logic [31:0] word;
            word = '0;
            for (int k = 0; k < 4; k++)
               if (w * 4 + k < n) word[k*8 +: 8] = b[w*4+k];
            exp_pld.push_back(word);
         end
         exp_hdr.push_back({c16[15:8], c16[7:0], dt});
         cons = n;
      end else begin
         b.push_back(seed);
         b.push_back(seed ^ 8'hA5);
         if (kind == 0) begin
            exp_hdr.push_back({b[1], b[0], dt});
            cons = 2;
         end
      end
      seed = seed + 8'h3D;
      exp_done.push_back(code);
      cur_tag = tag;
      foreach (b[i]) bq.push_back(b[i]);
      consumed = 0;
      req_seen = 0;
      d0 = dones;
      @(negedge clk);
      req_dtype = dt;
      req_count = c16;
      link_mode = mode;
      req_valid = 1'b1;
      while (!req_seen) @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (dones == d0) @(posedge clk);
      check(consumed == cons, {tag, " bytes consumed"}, consumed, cons);
      check(exp_pld.size() == 0 && exp_hdr.size() == 0, {tag, " words outstanding"},
            exp_pld.size() + exp_hdr.size(), 0);
      bq.delete();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R11 watchdog: actual hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(req_ready && !pld_valid && !hdr_valid && !done_valid, "R11 reset state",
            {req_ready, pld_valid, hdr_valid, done_valid}, 4'b1000);

      // R8 header-only types
      do_req(8'h05, 0, 2'd2, 0, 2'd0, "R8 short write");
      do_req(8'h15, 1, 2'd0, 0, 2'd0, "R8 short write param");
      do_req(8'h37, 2, 2'd2, 0, 2'd0, "R8 return size");
      do_req(8'h12, 0, 2'd2, 0, 2'd0, "R8 peripheral control");
      do_req(8'h14, 0, 2'd2, 0, 2'd0, "R8 read request");

      // R4 R5 R6 R7 long writes
      do_req(8'h39, 4,   2'd2, 1, 2'd0, "R4 long four bytes");
      do_req(8'h29, 13,  2'd2, 1, 2'd0, "R5 long partial word");
      stall_en = 1;
      do_req(8'h39, 7,   2'd2, 1, 2'd0, "R11 long under back-pressure");
      do_req(8'h12, 0,   2'd2, 0, 2'd0, "R11 short under back-pressure");
      stall_en = 0;
      do_req(8'h29, 2,   2'd2, 1, 2'd0, "R6 long small count");
      do_req(8'h39, 0,   2'd2, 1, 2'd0, "R6 long zero count");
      do_req(8'h29, 300, 2'd2, 1, 2'd0, "R7 long count high byte");

      // R9 skip types
      do_req(8'h09, 0, 2'd2, 2, 2'd0, "R9 null packet");
      do_req(8'h21, 0, 2'd0, 2, 2'd0, "R9 sync event");
      do_req(8'h08, 0, 2'd2, 2, 2'd0, "R9 end of transmission");

      // R10 unsupported
      do_req(8'h3E, 0, 2'd2, 2, 2'd3, "R10 pixel stream");
      do_req(8'h07, 0, 2'd2, 2, 2'd3, "R10 unknown type");
      check(done_cyc - acc_cyc == 2, "R10 completion latency", done_cyc - acc_cyc, 2);

      // R1 ultra-low-power reject
      do_req(8'h29, 8, 2'd3, 2, 2'd1, "R1 asleep long");
      check(done_cyc - acc_cyc == 1, "R1 completion latency", done_cyc - acc_cyc, 1);
      do_req(8'h05, 0, 2'd3, 2, 2'd1, "R1 asleep short");

      // R2 drain wait that passes
      do_req(8'h05, 0, 2'd1, 0, 2'd0, "R2 low-power already empty");
      hdr_fifo_empty = 1'b0;
      writes = 0;
      fork
         do_req(8'h39, 5, 2'd1, 1, 2'd0, "R2 low-power after drain");
         begin
            repeat (40) @(posedge clk);
            @(negedge clk);
            #1.2;
            check(writes == 0 && consumed == 0, "R2 quiet during drain wait", writes + consumed, 0);
            @(negedge clk);
            hdr_fifo_empty = 1'b1;
         end
      join

      // R3 drain timeout
      hdr_fifo_empty = 1'b0;
      writes = 0;
      do_req(8'h15, 0, 2'd1, 2, 2'd2, "R3 drain timeout");
      check(done_cyc - acc_cyc == LIMIT + 1, "R3 timeout latency", done_cyc - acc_cyc, LIMIT + 1);
      check(writes == 0, "R3 nothing written", writes, 0);
      hdr_fifo_empty = 1'b1;
      do_req(8'h29, 6, 2'd1, 1, 2'd0, "R2 recovers after timeout");

      check(exp_done.size() == 0, "R11 all completions seen", exp_done.size(), 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule